// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Controller

This block sits between a host bus and a word-wide memory array and serves asynchronous reads. It keeps one page of eight words in a local buffer and remembers which page that is. A read whose page is not in the buffer fetches the whole page from the array and pays the long random-access latency. A read inside the buffered page is served from the buffer with the short page latency. The host presents an address with chip enable and output enable high, then waits for `data_rdy`.

When the bus has been quiet for a programmable number of cycles, which defaults to the cycle count equal to 150 ns at 125 MHz, the block raises `standby`. The last read result stays on `dout`. Any address change or chip-enable edge leaves standby on that same clock edge, and the read that follows costs no extra cycles. The wait output is held low throughout, because asynchronous reads never stall the bus. Reads are served only when the configuration bit that selects asynchronous mode (bit 15 of the configuration register, supplied on `mode_async`) is 1.

Top module: `async_page_reader`

## Requirements
- R1: The page is `addr[15:3]` and the word within the page is `addr[2:0]`. A completed read shows on `dout` the array word at the address that was requested.
- R2: A read whose page is not buffered raises `data_rdy` RAND_LAT (default 7) rising edges after the edge that samples the new address. It pulses `arr_rd_en` for one cycle with that page on `arr_page`.
- R3: A read inside the buffered page raises `data_rdy` PAGE_LAT (default 2) edges after the edge that samples the address. It issues no array read.
- R4: A change of `addr[15:3]` to a page other than the buffered one costs RAND_LAT again, even after an earlier page was loaded. The new page replaces the old one in the buffer.
- R5: After IDLE_CYCLES (default 19) edges with no activity, `standby` goes high. `data_rdy` and `dout` keep their values while `standby` is high.
- R6: An address change or a chip-enable edge clears `standby` at the edge that samples it. A buffered-page read started from standby still completes in PAGE_LAT.
- R7: `wait_o` is 0 at all times.
- R8: While `mode_async` is 0, no read is served: `data_rdy` stays 0 and `arr_rd_en` stays 0. Setting it to 1 starts a read of the present address at full random latency.
- R9: Deasserting `chip_en` clears `data_rdy` and invalidates the buffer. The next read, even to the same page, costs RAND_LAT.
- R10: An address change during an unfinished read abandons that read and times the new one from the change. A page whose fetch was abandoned is not buffered.
- R11: With `out_en` low, `data_rdy` and `dout` read 0 and the read still completes. Raising `out_en` shows the finished word in the same cycle.
- R12: During reset, `data_rdy`, `dout`, `standby` and `arr_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_async | input | 1 | Configuration bit 15; 1 selects asynchronous reads |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high |
| addr | input | 16 | Word address from the host |
| arr_rd_en | output | 1 | One-cycle page fetch request to the array |
| arr_page | output | 13 | Page being fetched, held until the next fetch |
| arr_page_data | input | 128 | All eight words of `arr_page`, word n at bits n*16 upward |
| dout | output | 16 | Read data, 0 when not ready |
| data_rdy | output | 1 | Read data valid |
| standby | output | 1 | Low-power state after bus inactivity |
| wait_o | output | 1 | Bus wait, always deasserted |

## Verification
The hardest state to reach is a buffer holding a page other than the one whose fetch was last requested. This happens when a miss is overtaken by an address in another page before it finishes. The stimulus moves the address three cycles into a fetch, lets the second fetch complete, and then reads the abandoned page to show that it still misses. Standby is reached by holding every input still for longer than the timeout while a finished read is on the outputs. The stimulus then leaves standby with a hit, so that any added wake-up cycle would show as a longer page latency.

// File: rtl/apr_pkg.sv
// Package: shared definitions for the asynchronous page-mode read controller.
// Assumes: nothing beyond IEEE 1800-2017.
package apr_pkg;
    // Where the word of a finishing read comes from.
    typedef enum logic {
        SRC_BUFFER = 1'b0,
        SRC_ARRAY  = 1'b1
    } word_src_e;
endpackage

// File: rtl/apr_page_buffer.sv
// Module: apr_page_buffer
// Holds one page of words, its page tag and a valid flag, and reports a hit
// when the looked-up tag matches the buffered page.
// Assumes: load and inval are never high in the same cycle (the top only
// loads while enabled and only invalidates on the enable's falling edge).
module apr_page_buffer #(
    parameter int TAG_W      = 13,
    parameter int DATA_W     = 16,
    parameter int PAGE_BITS  = 3,
    localparam int PAGE_WORDS = 1 << PAGE_BITS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         inval,
    input  logic                         load,
    input  logic [TAG_W-1:0]             load_tag,
    input  logic [PAGE_WORDS*DATA_W-1:0] load_data,
    input  logic [TAG_W-1:0]             look_tag,
    input  logic [PAGE_BITS-1:0]         rd_idx,
    output logic                         hit,
    output logic [DATA_W-1:0]            rd_word
);
    logic              valid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] words_q [PAGE_WORDS];

    // Tag and valid flag: invalidation wins, a load marks the page present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            tag_q   <= load_tag;
        end
    end

    // Word storage, one register per word, filled together on a load.
    for (genvar g = 0; g < PAGE_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (load) begin
                words_q[g] <= load_data[g*DATA_W +: DATA_W];
            end
        end
    end

    assign hit     = valid_q && (tag_q == look_tag);
    assign rd_word = words_q[rd_idx];

    // R9
    inval_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> !hit);
endmodule

// File: rtl/apr_access_timer.sv
// Module: apr_access_timer
// Counts the latency of one read. start loads the length, abort cancels,
// fire marks the cycle whose edge completes the read, done holds until the
// next start or abort.
// Assumes: len >= 1.
module apr_access_timer #(
    parameter int LAT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] len,
    input  logic             abort,
    output logic             fire,
    output logic             done
);
    logic             busy_q;
    logic [LAT_W-1:0] cnt_q;

    assign fire = busy_q && (cnt_q == '0) && !start && !abort;

    // Countdown: abort clears, start reloads, fire completes, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done   <= 1'b0;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            done   <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            done   <= 1'b0;
            cnt_q  <= len - LAT_W'(1);
        end else if (fire) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - LAT_W'(1);
        end
    end

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy_q));
endmodule

// File: rtl/apr_idle_monitor.sv
// Module: apr_idle_monitor
// Counts edges without bus activity and raises standby once the count
// reaches IDLE_CYCLES; activity clears both at once.
// Assumes: IDLE_CYCLES >= 1.
module apr_idle_monitor #(
    parameter int IDLE_CYCLES = 19,
    localparam int IW = $clog2(IDLE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    output logic standby
);
    logic [IW-1:0] idle_q;

    // Inactivity count and standby flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= '0;
            standby <= 1'b0;
        end else if (act) begin
            idle_q  <= '0;
            standby <= 1'b0;
        end else if (idle_q == IW'(IDLE_CYCLES - 1)) begin
            standby <= 1'b1;
        end else begin
            idle_q  <= idle_q + IW'(1);
        end
    end

    // R6
    wake_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !standby);
    // R5
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby) |-> $past(!act));
endmodule

// File: rtl/async_page_reader.sv
// Module: async_page_reader (top)
// Serves asynchronous word reads through a one-page buffer: misses fetch
// the page from the array and take RAND_LAT cycles, hits take PAGE_LAT.
// Raises standby after IDLE_CYCLES quiet edges; wait_o is held low.
// Assumes: the array presents the full page of arr_page on arr_page_data
// within RAND_LAT-1 cycles of arr_rd_en and holds it until the next fetch;
// PAGE_LAT >= 1 and RAND_LAT >= PAGE_LAT.
module async_page_reader
    import apr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int PAGE_BITS   = 3,
    parameter int RAND_LAT    = 7,
    parameter int PAGE_LAT    = 2,
    parameter int IDLE_CYCLES = 19
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 mode_async,
    input  logic                                 chip_en,
    input  logic                                 out_en,
    input  logic [ADDR_W-1:0]                    addr,
    output logic                                 arr_rd_en,
    output logic [ADDR_W-PAGE_BITS-1:0]          arr_page,
    input  logic [(DATA_W<<PAGE_BITS)-1:0]       arr_page_data,
    output logic [DATA_W-1:0]                    dout,
    output logic                                 data_rdy,
    output logic                                 standby,
    output logic                                 wait_o
);
    localparam int TAG_W = ADDR_W - PAGE_BITS;
    localparam int LAT_W = $clog2(RAND_LAT + 1);

    logic                 en, en_q, act, req, inval, hit, fire, done;
    logic [ADDR_W-1:0]    addr_q;
    logic [TAG_W-1:0]     tag_in;
    logic [PAGE_BITS-1:0] idx_q;
    logic [LAT_W-1:0]     lat_sel;
    logic [DATA_W-1:0]    word_q, buf_word, arr_word;
    word_src_e            src_q;

    assign en      = chip_en & mode_async;
    assign act     = (addr != addr_q) | (en != en_q);
    assign req     = en & ((addr != addr_q) | ~en_q);
    assign inval   = en_q & ~en;
    assign tag_in  = addr[ADDR_W-1:PAGE_BITS];
    assign idx_q   = addr_q[PAGE_BITS-1:0];
    assign lat_sel = hit ? LAT_W'(PAGE_LAT) : LAT_W'(RAND_LAT);
    assign arr_word = arr_page_data[idx_q*DATA_W +: DATA_W];

    // Remember the bus as last sampled, to detect changes and edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            en_q   <= 1'b0;
        end else begin
            addr_q <= addr;
            en_q   <= en;
        end
    end

    // Issue a page fetch on a miss and note where the result will come from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_rd_en <= 1'b0;
            arr_page  <= '0;
            src_q     <= SRC_BUFFER;
        end else begin
            arr_rd_en <= req & ~hit;
            if (req & ~hit) arr_page <= tag_in;
            if (req)        src_q    <= hit ? SRC_BUFFER : SRC_ARRAY;
        end
    end

    // Capture the word of a finishing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (fire) begin
            word_q <= (src_q == SRC_ARRAY) ? arr_word : buf_word;
        end
    end

    apr_page_buffer #(
        .TAG_W    (TAG_W),
        .DATA_W   (DATA_W),
        .PAGE_BITS(PAGE_BITS)
    ) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .inval    (inval),
        .load     (fire && (src_q == SRC_ARRAY)),
        .load_tag (arr_page),
        .load_data(arr_page_data),
        .look_tag (tag_in),
        .rd_idx   (idx_q),
        .hit      (hit),
        .rd_word  (buf_word)
    );

    apr_access_timer #(
        .LAT_W(LAT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(req),
        .len  (lat_sel),
        .abort(~en),
        .fire (fire),
        .done (done)
    );

    apr_idle_monitor #(
        .IDLE_CYCLES(IDLE_CYCLES)
    ) u_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .act    (act),
        .standby(standby)
    );

    assign data_rdy = done & out_en;
    assign dout     = data_rdy ? word_q : '0;
    assign wait_o   = 1'b0;

    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!done && !arr_rd_en));
    // R3
    hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && hit) |=> !arr_rd_en);
endmodule

// File: tb/tb_async_page_reader.sv
module tb_async_page_reader;
    localparam int RAND_LAT = 7;
    localparam int PAGE_LAT = 2;
    localparam int IDLE     = 19;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_async = 1'b0;
    logic         chip_en = 1'b0;
    logic         out_en = 1'b0;
    logic [15:0]  addr = '0;
    logic         arr_rd_en;
    logic [12:0]  arr_page;
    logic [127:0] arr_page_data;
    logic [15:0]  dout;
    logic         data_rdy, standby, wait_o;

    int    checks = 0;
    int    fails = 0;
    string ctx = "R12";

    always #4 clk = ~clk;

    async_page_reader dut (
        .clk(clk), .rst_n(rst_n), .mode_async(mode_async), .chip_en(chip_en),
        .out_en(out_en), .addr(addr), .arr_rd_en(arr_rd_en), .arr_page(arr_page),
        .arr_page_data(arr_page_data), .dout(dout), .data_rdy(data_rdy),
        .standby(standby), .wait_o(wait_o)
    );

    function automatic logic [15:0] pat(logic [15:0] a);
        return (a * 16'h9E37) ^ 16'h5A5A;
    endfunction

    // Array model: the whole page of arr_page, word n in slice n.
    always_comb begin
        for (int w = 0; w < 8; w++)
            arr_page_data[w*16 +: 16] = pat({arr_page, w[2:0]});
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic [15:0] m_pa, m_word;
    bit m_pen, m_valid, m_busy, m_done, m_miss, m_arr, m_sb, m_en, m_act, m_req, m_hit;
    int m_tag, m_ftag, m_rem, m_ic;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pa = '0; m_pen = 0; m_valid = 0; m_tag = 0; m_busy = 0; m_done = 0;
            m_rem = 0; m_miss = 0; m_arr = 0; m_ic = 0; m_sb = 0; m_word = '0;
        end else begin
            m_en  = chip_en && mode_async;
            m_act = (addr != m_pa) || (m_en != m_pen);
            m_req = m_en && ((addr != m_pa) || !m_pen);
            m_hit = m_valid && (int'(addr >> 3) == m_tag);
            if (m_pen && !m_en) m_valid = 0;
            m_arr = m_req && !m_hit;
            if (!m_en) begin
                m_busy = 0; m_done = 0;
            end else if (m_req) begin
                m_busy = 1; m_done = 0; m_miss = !m_hit;
                m_rem  = (m_hit ? PAGE_LAT : RAND_LAT) - 1;
                m_ftag = int'(addr >> 3);
            end else if (m_busy) begin
                if (m_rem == 0) begin
                    m_busy = 0; m_done = 1; m_word = pat(m_pa);
                    if (m_miss) begin m_valid = 1; m_tag = m_ftag; end
                end else m_rem--;
            end
            if (m_act) begin m_ic = 0; m_sb = 0; end
            else if (m_ic == IDLE - 1) m_sb = 1;
            else m_ic++;
            m_pa = addr; m_pen = m_en;
        end
    end

    // Cycle-by-cycle comparison, away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            check(data_rdy == (m_done && out_en), ctx, "data_rdy", data_rdy, m_done && out_en);
            check(dout == ((m_done && out_en) ? m_word : 16'h0), ctx, "dout", dout,
                  (m_done && out_en) ? m_word : 16'h0);
            check(arr_rd_en == m_arr, ctx, "arr_rd_en", arr_rd_en, m_arr);
            check(standby == m_sb, "R5", "standby", standby, m_sb);
            check(wait_o == 1'b0, "R7", "wait_o", wait_o, 0);
        end
    end

    int first_sb;

    // Count edges from the request edge until data_rdy, then check latency and data.
    task automatic measure(int exp_lat, string tag, logic [15:0] a);
        int n = 0;
        @(posedge clk); #2;
        first_sb = standby;
        while (n < 50) begin
            @(posedge clk); #2;
            n++;
            if (data_rdy) break;
        end
        check(n == exp_lat, tag, "latency", n, exp_lat);
        check(dout == pat(a), "R1", "dout", dout, pat(a));
    endtask

    task automatic access(logic [15:0] a, int exp_lat, string tag);
        @(negedge clk);
        addr = a;
        ctx  = tag;
        measure(exp_lat, tag, a);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check(data_rdy == 0 && dout == 0, "R12", "rdy/dout in reset", dout, 0);
        check(standby == 0 && arr_rd_en == 0, "R12", "standby/fetch in reset", standby, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: first read, page miss
        @(negedge clk);
        mode_async = 1'b1; chip_en = 1'b1; out_en = 1'b1; addr = 16'h0120; ctx = "R2";
        measure(RAND_LAT, "R2", 16'h0120);
        // R3: hits in the loaded page
        access(16'h0125, PAGE_LAT, "R3");
        access(16'h0127, PAGE_LAT, "R3");
        // R4: other page, then back to the first
        access(16'h0238, RAND_LAT, "R4");
        access(16'h0121, RAND_LAT, "R4");
        access(16'h0122, PAGE_LAT, "R3");

        // R5: inactivity into standby, outputs kept
        ctx = "R5";
        repeat (IDLE + 6) @(posedge clk);
        #2;
        check(standby == 1, "R5", "standby after quiet", standby, 1);
        check(data_rdy == 1 && dout == pat(16'h0122), "R5", "dout held in standby", dout, pat(16'h0122));

        // R6: leave standby with a hit, no extra latency
        access(16'h0123, PAGE_LAT, "R6");
        check(first_sb == 0, "R6", "standby after wake edge", first_sb, 0);

        // R9: chip enable drop invalidates the buffer
        @(negedge clk);
        chip_en = 1'b0; ctx = "R9";
        @(posedge clk); #2;
        check(data_rdy == 0, "R9", "rdy after disable", data_rdy, 0);
        @(negedge clk);
        chip_en = 1'b1;
        measure(RAND_LAT, "R9", 16'h0123);

        // R10: move to another page three cycles into a fetch
        @(negedge clk);
        addr = 16'h0400; ctx = "R10";
        repeat (3) @(posedge clk);
        access(16'h0410, RAND_LAT, "R10");
        access(16'h0402, RAND_LAT, "R10");

        // R11: output enable gating
        @(negedge clk);
        out_en = 1'b0; addr = 16'h0403; ctx = "R11";
        repeat (5) @(posedge clk);
        #2;
        check(data_rdy == 0 && dout == 0, "R11", "gated output", dout, 0);
        @(negedge clk);
        out_en = 1'b1;
        #1;
        check(data_rdy == 1, "R11", "rdy on out_en", data_rdy, 1);
        check(dout == pat(16'h0403), "R11", "dout on out_en", dout, pat(16'h0403));

        // R8: asynchronous mode bit cleared
        @(negedge clk);
        mode_async = 1'b0; addr = 16'h0500; ctx = "R8";
        repeat (10) @(posedge clk);
        #2;
        check(data_rdy == 0, "R8", "rdy with mode off", data_rdy, 0);
        @(negedge clk);
        mode_async = 1'b1;
        measure(RAND_LAT, "R8", 16'h0500);

        // R7: wait output
        check(wait_o == 0, "R7", "wait_o", wait_o, 0);

        repeat (2) @(posedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule